// File: doc/BRIEF.md
# Byte/Word Flash Host Bus Front End

This block is the host-side bus front end of a parallel NOR-style flash device, written as a synchronous model. On every clock it samples the active-low chip select, output gate, write strobe and bus reset, plus the width select, the word address and the inbound data lanes. From these it decodes one of three bus operations: read, write or idle. A read returns a word from a small synchronous storage array, either as a full 16-bit word or as one byte on the low lanes. A write captures the address and data into a command latch, which has no place in the memory map. It raises a one-cycle pulse so that a downstream command engine can take the command.

Width select high gives word operation. Width select low gives byte operation: the upper lanes stay undriven, and inbound lane 15 serves as one more address bit below the word address. After system reset or a bus reset, the controller is in read-array mode. Reads need no prior command, and the mode flag stays set until a command is captured. The storage is filled through a simple load port before the bus is used.

Top module: `nor_bus_front`

## Requirements
- R1: After system reset `dq_oe` is all zero, `cmd_valid` is 0 and `array_mode` is 1.
- R2: With `ce_n`=0, `oe_n`=0, `we_n`=1, `bus_rst_n`=1 and `byte_n`=1 held, two clock edges later `dq_oe`=16'hFFFF and `dq_out` equals the stored word at index `addr[7:0]` (the words are written earlier through `ld_en`/`ld_idx`/`ld_data`).
- R3: The same read with `byte_n`=0 gives `dq_oe`=16'h00FF. `dq_out[7:0]` is bits 7:0 of the addressed word when `dq_in[15]`=0 and bits 15:8 when `dq_in[15]`=1.
- R4: With `ce_n`=0 and both `oe_n` and `we_n` high, `dq_oe` is all zero.
- R5: With `ce_n`=1, `dq_oe` is all zero whatever the other controls are.
- R6: With `ce_n`=0 and both `oe_n` and `we_n` low, `dq_oe` is all zero and no command is captured.
- R7: With `bus_rst_n`=0, `dq_oe` is all zero and no command is captured. Two edges later `array_mode` is 1.
- R8: A word-mode write (`ce_n`=0, `we_n`=0, `oe_n`=1, `bus_rst_n`=1, `byte_n`=1) raises `cmd_valid` for exactly one cycle, two edges after it is applied, even if the write is held longer. The latch then holds `cmd_addr`={addr,1'b0}, `cmd_data`=`dq_in` and `cmd_byte`=0.
- R9: A byte-mode write (`byte_n`=0) latches `cmd_addr`={addr,dq_in[15]}, `cmd_data`={8'h00,dq_in[7:0]} and `cmd_byte`=1.
- R10: A captured command clears `array_mode`. Reads still return array data afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| bus_rst_n | input | 1 | Bus-side reset, active low |
| byte_n | input | 1 | 1 = word width, 0 = byte width |
| addr | input | 18 | Word address |
| dq_in | input | 16 | Inbound data lanes; lane 15 is the byte-select address bit in byte mode |
| dq_out | output | 16 | Outbound data lanes |
| dq_oe | output | 16 | Per-lane drive enables |
| ld_en | input | 1 | Storage load strobe |
| ld_idx | input | 8 | Storage load index |
| ld_data | input | 16 | Storage load word |
| cmd_valid | output | 1 | One-cycle pulse for a newly captured command |
| cmd_addr | output | 19 | Latched byte-granular address |
| cmd_data | output | 16 | Latched command data |
| cmd_byte | output | 1 | Latched command was a byte-mode write |
| array_mode | output | 1 | Controller is in read-array mode |

## Verification
A bus reset and a command capture both drive the mode flag. The reset must win, so writes are applied with `bus_rst_n` low and the bench checks that no pulse appears and the flag reads 1. Output drive and command capture are also tested against each other. A cycle with both `oe_n` and `we_n` low must yield neither. Holding a write across several cycles must yield exactly one pulse, while a read that follows still drives array data.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/nbf_decode.sv
module nbf_decode
  import nbf_pkg::*;
(
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    brst_n,
  output bus_op_e op
);
  logic sel;
  assign sel = !ce_n && brst_n;

  always_comb begin
    op = OP_IDLE;
    if (sel && !oe_n && we_n)      op = OP_READ;
    else if (sel && oe_n && !we_n) op = OP_WRITE;
    // both strobes low, or deselected, or in bus reset: idle
  end
endmodule

// File: rtl/nbf_array.sv
module nbf_array #(
  parameter int IDX_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/nbf_cmd_latch.sv
module nbf_cmd_latch #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          brst_ok,
  input  logic          byte_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_byte,
  output logic          array_mode
);
  localparam int HALF = DW / 2;

  logic          prev_wr_q;
  logic          capture;
  logic          mode_d;
  logic [AW:0]   addr_d;
  logic [DW-1:0] data_d;

  assign capture = wr_hit && !prev_wr_q;

  always_comb begin
    mode_d = array_mode;
    if (capture) mode_d = 1'b0;
    if (!brst_ok) mode_d = 1'b1;
    if (byte_mode) begin
      addr_d = {addr, dq[DW-1]};
      data_d = {{HALF{1'b0}}, dq[HALF-1:0]};
    end else begin
      addr_d = {addr, 1'b0};
      data_d = dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr_q  <= 1'b0;
      cmd_valid  <= 1'b0;
      array_mode <= 1'b1;
    end else begin
      prev_wr_q  <= wr_hit;
      cmd_valid  <= capture;
      array_mode <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_byte <= 1'b0;
    end else if (capture) begin
      cmd_addr <= addr_d;
      cmd_data <= data_d;
      cmd_byte <= byte_mode;
    end
  end

  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_cmd_clears_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !array_mode);
  p_busrst_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !brst_ok |=> (array_mode && !cmd_valid));
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          bus_rst_n,
  input  logic          byte_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  input  logic          ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_byte,
  output logic          array_mode
);
  localparam int HALF = DW / 2;

  // sampled bus
  logic          s_ce_n, s_oe_n, s_we_n, s_brst_n, s_byte_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n   <= 1'b1;
      s_oe_n   <= 1'b1;
      s_we_n   <= 1'b1;
      s_brst_n <= 1'b1;
      s_byte_n <= 1'b1;
      s_addr   <= '0;
      s_dq     <= '0;
    end else begin
      s_ce_n   <= ce_n;
      s_oe_n   <= oe_n;
      s_we_n   <= we_n;
      s_brst_n <= bus_rst_n;
      s_byte_n <= byte_n;
      s_addr   <= addr;
      s_dq     <= dq_in;
    end
  end

  bus_op_e op;

  nbf_decode u_decode (
    .ce_n   (s_ce_n),
    .oe_n   (s_oe_n),
    .we_n   (s_we_n),
    .brst_n (s_brst_n),
    .op     (op)
  );

  logic          rd_go;
  logic [DW-1:0] arr_q;

  assign rd_go = (op == OP_READ);

  nbf_array #(.IDX_W(IDX_W), .DW(DW)) u_array (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .rd_en   (rd_go),
    .rd_idx  (s_addr[IDX_W-1:0]),
    .rd_data (arr_q)
  );

  nbf_cmd_latch #(.AW(AW), .DW(DW)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (op == OP_WRITE),
    .brst_ok    (s_brst_n),
    .byte_mode  (!s_byte_n),
    .addr       (s_addr),
    .dq         (s_dq),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_byte   (cmd_byte),
    .array_mode (array_mode)
  );

  // lane steering: next-state and register
  logic [DW-1:0] oe_d, oe_q;
  logic          hi_sel_d, hi_sel_q, byte_d, byte_q;

  always_comb begin
    oe_d     = '0;
    hi_sel_d = hi_sel_q;
    byte_d   = byte_q;
    if (rd_go) begin
      byte_d   = !s_byte_n;
      hi_sel_d = !s_byte_n && s_dq[DW-1];
      oe_d     = s_byte_n ? {DW{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= '0;
      hi_sel_q <= 1'b0;
      byte_q   <= 1'b0;
    end else begin
      oe_q     <= oe_d;
      hi_sel_q <= hi_sel_d;
      byte_q   <= byte_d;
    end
  end

  always_comb begin
    if (byte_q) dq_out = {{HALF{1'b0}}, hi_sel_q ? arr_q[DW-1:HALF] : arr_q[HALF-1:0]};
    else        dq_out = arr_q;
  end

  assign dq_oe = oe_q;

  p_standby_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ce_n |=> (dq_oe == '0));
  p_disable_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ce_n && s_oe_n && s_we_n) |=> (dq_oe == '0));
  p_conflict_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ce_n && !s_oe_n && !s_we_n) |=> (dq_oe == '0 && !cmd_valid));
  p_busrst_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_brst_n |=> (dq_oe == '0));
  p_byte_upper_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_byte_n |=> (dq_oe[DW-1:HALF] == '0));
endmodule

// File: tb/nor_bus_front_bench.sv
module nor_bus_front_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n, bus_rst_n, byte_n;
  logic [17:0] addr;
  logic [15:0] dq_in, dq_out, dq_oe;
  logic        ld_en;
  logic [7:0]  ld_idx;
  logic [15:0] ld_data;
  logic        cmd_valid, cmd_byte, array_mode;
  logic [18:0] cmd_addr;
  logic [15:0] cmd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  nor_bus_front u_nor_bus_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .bus_rst_n(bus_rst_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte), .array_mode(array_mode)
  );

  function automatic logic [15:0] pat(int i);
    return 16'((i * 257) ^ 16'h5A3C);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic c, logic o, logic w, logic br, logic bn,
                       logic [17:0] a, logic [15:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; bus_rst_n = br; byte_n = bn;
    addr = a; dq_in = d;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic go_idle();
    drive(1, 1, 1, 1, 1, '0, '0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dq_oe", 32'(dq_oe), 32'h0);
    chk("R1 cmd_valid", 32'(cmd_valid), 32'h0);
    chk("R1 array_mode", 32'(array_mode), 32'h1);
  endtask

  task automatic t_preload();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 8'(i); ld_data = pat(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic t_word_read(logic [17:0] a);
    drive(0, 0, 1, 1, 1, a, 16'h1234);
    settle();
    chk("R2 word oe", 32'(dq_oe), 32'hFFFF);
    chk("R2 word data", 32'(dq_out), 32'(pat(int'(a[7:0]))));
    go_idle();
  endtask

  task automatic t_byte_read(logic [17:0] a, logic hi);
    logic [15:0] w;
    w = pat(int'(a[7:0]));
    drive(0, 0, 1, 1, 0, a, {hi, 15'h7ABC});
    settle();
    chk("R3 byte oe", 32'(dq_oe), 32'h00FF);
    chk("R3 byte data", 32'(dq_out[7:0]), hi ? 32'(w[15:8]) : 32'(w[7:0]));
    go_idle();
  endtask

  task automatic t_disable();
    drive(0, 1, 1, 1, 1, 18'h10, 16'h0);
    settle();
    chk("R4 disable oe", 32'(dq_oe), 32'h0);
    go_idle();
  endtask

  task automatic t_standby();
    drive(1, 0, 1, 1, 1, 18'h11, 16'h0);
    settle();
    chk("R5 standby read ctl", 32'(dq_oe), 32'h0);
    drive(1, 1, 0, 1, 0, 18'h11, 16'h0);
    settle();
    chk("R5 standby write ctl", 32'(dq_oe), 32'h0);
    chk("R5 standby no cmd", 32'(cmd_valid), 32'h0);
    go_idle();
  endtask

  task automatic t_conflict();
    drive(0, 0, 0, 1, 1, 18'h22, 16'hBEEF);
    @(posedge clk); @(negedge clk);
    chk("R6 conflict cmd early", 32'(cmd_valid), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R6 conflict oe", 32'(dq_oe), 32'h0);
    chk("R6 conflict cmd", 32'(cmd_valid), 32'h0);
    chk("R6 conflict mode", 32'(array_mode), 32'h1);
    go_idle();
  endtask

  task automatic t_word_write();
    drive(0, 1, 0, 1, 1, 18'h2_ABCD, 16'hC0DE);
    settle();
    chk("R8 pulse", 32'(cmd_valid), 32'h1);
    chk("R8 addr", 32'(cmd_addr), 32'({18'h2_ABCD, 1'b0}));
    chk("R8 data", 32'(cmd_data), 32'hC0DE);
    chk("R8 byte flag", 32'(cmd_byte), 32'h0);
    chk("R10 mode cleared", 32'(array_mode), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 single pulse", 32'(cmd_valid), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 held no repeat", 32'(cmd_valid), 32'h0);
    go_idle();
    drive(0, 0, 1, 1, 1, 18'h0_0042, 16'h0);
    settle();
    chk("R10 read after cmd oe", 32'(dq_oe), 32'hFFFF);
    chk("R10 read after cmd data", 32'(dq_out), 32'(pat(8'h42)));
    go_idle();
  endtask

  task automatic t_bus_reset();
    drive(0, 0, 1, 0, 1, 18'h33, 16'h0);
    settle();
    chk("R7 busrst oe", 32'(dq_oe), 32'h0);
    chk("R7 busrst mode", 32'(array_mode), 32'h1);
    drive(0, 1, 0, 0, 1, 18'h34, 16'hAAAA);
    settle();
    chk("R7 busrst no cmd", 32'(cmd_valid), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 busrst no cmd late", 32'(cmd_valid), 32'h0);
    chk("R7 latch kept", 32'(cmd_data), 32'hC0DE);
    go_idle();
  endtask

  task automatic t_byte_write(logic hi);
    drive(0, 1, 0, 1, 0, 18'h1_5555, {hi, 7'h3F, 8'hA7});
    settle();
    chk("R9 pulse", 32'(cmd_valid), 32'h1);
    chk("R9 addr", 32'(cmd_addr), 32'({18'h1_5555, hi}));
    chk("R9 data", 32'(cmd_data), 32'h00A7);
    chk("R9 byte flag", 32'(cmd_byte), 32'h1);
    go_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; we_n = 1; bus_rst_n = 1; byte_n = 1;
    addr = '0; dq_in = '0; ld_en = 0; ld_idx = '0; ld_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preload();
    t_word_read(18'h0_0000);
    t_word_read(18'h0_00FF);
    t_word_read(18'h3_FF05);
    t_byte_read(18'h0_0017, 1'b0);
    t_byte_read(18'h0_0017, 1'b1);
    t_byte_read(18'h0_00C3, 1'b1);
    t_disable();
    t_standby();
    t_conflict();
    t_word_write();
    t_bus_reset();
    t_byte_write(1'b1);
    t_byte_write(1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule